// File: doc/BRIEF.md
# Shared Index/Data Configuration Port Decoder

This block sits between a processor core's I/O request path and the external I/O bus. It observes every I/O cycle issued by the core. Port 22h is an index port, and port 23h is the matching data port. The block keeps a small on-chip configuration register file behind this port pair. An external chipset can place its own registers behind the same two ports.

A write to the index port always latches the index inside the block. The same write is also passed to the external bus, so the chipset sees the identical index. A following data-port access is handled according to that latched index:

- **Claimed indexes** are C0h to CFh, FEh and FFh. A data access to one of these is served inside the block within the same cycle, and the external request stays low.
- **All other indexes** are forwarded unchanged. For a forwarded read, the byte returned by the bus is passed back to the core exactly as received.

Each data access uses up the latched index, so every data access needs a fresh index write before it.

The first `NUM_IMPL` indexes from C0h hold real registers. The remaining claimed indexes in the C0h–CFh range read as zero and discard writes. FEh and FFh are fixed identification bytes. One bit of one register acts as a mapping-enable control and is brought out as an output.

Top module: `cfgport_decoder`

## Requirements
- R1: A core write to address 0022h latches the written byte as the index and marks it valid. The same cycle drives ext_req=1, ext_wr=1, ext_addr=0022h and ext_wdata equal to the written byte.
- R2: A core access to address 0023h is claimed when the index is valid and lies in C0h–CFh or equals FEh or FFh. During a claimed access ext_req stays 0, and a read returns the internal value on io_rdata in the same cycle.
- R3: A data access whose valid index is outside the claimed set is forwarded with ext_req=1 and the same direction, address and write data. It leaves every on-chip register unchanged.
- R4: A forwarded read returns ext_rdata unchanged on io_rdata, including 00h and FFh.
- R5: Any access to address 0023h clears the index-valid flag. A data access made without a new index write is therefore forwarded.
- R6: Indexes C0h to C0h+NUM_IMPL−1 are read/write byte registers. The default NUM_IMPL is 4, giving C0h–C3h. A write takes effect at the next clock edge.
- R7: Claimed indexes from C0h+NUM_IMPL up to CFh read as 00h, and writes to them are discarded.
- R8: Index FEh reads ID_LO (default 5Ah) and index FFh reads ID_HI (default 3Ch). Writes to either are ignored.
- R9: Bit 4 of register C3h is the mapping-enable bit and drives map_en. It resets to 0.
- R10: After reset every implemented register reads 00h and no index is valid.
- R11: Core accesses to any address other than 0023h, including reads of 0022h, are forwarded unchanged. With no core strobe, ext_req is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Core I/O address |
| io_rd | input | 1 | Core read strobe, one cycle |
| io_wr | input | 1 | Core write strobe, one cycle |
| io_wdata | input | 8 | Core write data |
| io_rdata | output | 8 | Read data returned to the core |
| ext_req | output | 1 | External I/O cycle request |
| ext_wr | output | 1 | External cycle direction (1 = write) |
| ext_addr | output | 16 | External I/O address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | Read data from the external bus |
| map_en | output | 1 | Mapping-enable bit from register C3h |

## Verification
Some rules are checked by assertions on every cycle:

- An index write is always forwarded and always sets the valid flag.
- A data access always consumes the index.
- A claimed data access never raises ext_req.
- The register file stays still unless its write enable is asserted.
- map_en is low right after reset.

Other behaviour can only be shown by the bench's sweep of all 256 index values:

- The exact split between claimed and forwarded indexes.
- The zero reads of empty slots.
- Ignored writes to the identification bytes.
- Pass-through of 00h and FFh from the bus.
- Forwarding of a data access that has no fresh index.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam logic [15:0] PORT_INDEX = 16'h0022;
    localparam logic [15:0] PORT_DATA  = 16'h0023;
    localparam logic [7:0]  CFG_FIRST  = 8'hC0;
    localparam logic [7:0]  CFG_LAST   = 8'hCF;
    localparam logic [7:0]  IDLO_IDX   = 8'hFE;
    localparam logic [7:0]  IDHI_IDX   = 8'hFF;

    typedef enum logic [1:0] {
        SLOT_NONE  = 2'd0,
        SLOT_REG   = 2'd1,
        SLOT_EMPTY = 2'd2,
        SLOT_ID    = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic [3:0] offs;
        logic       id_hi;
    } slot_t;

    typedef struct packed {
        logic        claim;
        logic        fwd;
        logic        is_wr;
        slot_t       slot;
    } route_t;

    function automatic logic in_claimed(input logic [7:0] idx);
        return (idx >= CFG_FIRST && idx <= CFG_LAST) || idx == IDLO_IDX || idx == IDHI_IDX;
    endfunction

    function automatic slot_t classify(input logic [7:0] idx, input int unsigned n_impl);
        slot_t s;
        s.kind  = SLOT_NONE;
        s.offs  = idx[3:0];
        s.id_hi = idx[0];
        if (idx >= CFG_FIRST && idx <= CFG_LAST) begin
            if (32'(idx[3:0]) < n_impl) s.kind = SLOT_REG;
            else                        s.kind = SLOT_EMPTY;
        end else if (idx == IDLO_IDX || idx == IDHI_IDX) begin
            s.kind = SLOT_ID;
        end
        return s;
    endfunction

endpackage

// File: rtl/cfg_index_latch.sv
module cfg_index_latch
    import cfgport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  idx_q,
    output logic        idx_valid
);
    logic idx_load;
    logic data_touch;

    assign idx_load   = io_wr && (io_addr == PORT_INDEX);
    assign data_touch = (io_rd || io_wr) && (io_addr == PORT_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            idx_valid <= 1'b0;
        end else if (idx_load) begin
            idx_q     <= io_wdata;
            idx_valid <= 1'b1;
        end else if (data_touch) begin
            idx_valid <= 1'b0;
        end
    end

    // R5: a data-port access leaves no usable index behind
    a_r5_data_consumes_index: assert property (@(posedge clk) disable iff (rst)
        ((io_rd || io_wr) && io_addr == PORT_DATA) |=> !idx_valid);

    // R1: an index write is held for the next data access
    a_r1_index_latched: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == PORT_INDEX) |=> (idx_valid && idx_q == $past(io_wdata)));

endmodule

// File: rtl/cfg_route.sv
module cfg_route
    import cfgport_pkg::*;
#(
    parameter int unsigned NUM_IMPL = 4
) (
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [7:0]  idx_q,
    input  logic        idx_valid,
    output route_t      route
);
    logic  any_req;
    logic  data_port;
    slot_t slot;

    assign any_req   = io_rd || io_wr;
    assign data_port = io_addr == PORT_DATA;
    assign slot      = classify(idx_q, NUM_IMPL);

    always_comb begin
        route.slot  = slot;
        route.is_wr = io_wr;
        route.claim = any_req && data_port && idx_valid && (slot.kind != SLOT_NONE);
        route.fwd   = any_req && !route.claim;
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfgport_pkg::*;
#(
    parameter int unsigned NUM_IMPL   = 4,
    parameter int unsigned MAPEN_REG  = 3,
    parameter int unsigned MAPEN_BIT  = 4,
    parameter logic [7:0]  ID_LO      = 8'h5A,
    parameter logic [7:0]  ID_HI      = 8'h3C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        claim,
    input  logic        is_wr,
    input  slot_t       slot,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        map_en
);
    logic [NUM_IMPL-1:0][7:0] cfg_q;
    logic                     reg_we;

    assign reg_we = claim && is_wr && (slot.kind == SLOT_REG);

    for (genvar g = 0; g < NUM_IMPL; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[g] <= '0;
            else if (reg_we && 32'(slot.offs) == g)
                cfg_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (slot.kind)
            SLOT_REG: begin
                for (int i = 0; i < NUM_IMPL; i++)
                    if (32'(slot.offs) == i) rdata = cfg_q[i];
            end
            SLOT_ID:    rdata = slot.id_hi ? ID_HI : ID_LO;
            SLOT_EMPTY: rdata = '0;
            default:    rdata = '0;
        endcase
    end

    assign map_en = cfg_q[MAPEN_REG][MAPEN_BIT];

    // R3 / R7 / R8: without a register write enable the file holds still
    a_r3_regs_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(cfg_q));

    // R9: mapping enable comes out of reset cleared
    a_r9_mapen_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !map_en);

endmodule

// File: rtl/cfgport_decoder.sv
module cfgport_decoder
    import cfgport_pkg::*;
#(
    parameter int unsigned NUM_IMPL  = 4,
    parameter int unsigned MAPEN_REG = 3,
    parameter int unsigned MAPEN_BIT = 4,
    parameter logic [7:0]  ID_LO     = 8'h5A,
    parameter logic [7:0]  ID_HI     = 8'h3C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        ext_req,
    output logic        ext_wr,
    output logic [15:0] ext_addr,
    output logic [7:0]  ext_wdata,
    input  logic [7:0]  ext_rdata,
    output logic        map_en
);
    logic [7:0] idx_q;
    logic       idx_valid;
    route_t     route;
    logic [7:0] int_rdata;

    cfg_index_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .idx_q     (idx_q),
        .idx_valid (idx_valid)
    );

    cfg_route #(.NUM_IMPL(NUM_IMPL)) u_route (
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .idx_q     (idx_q),
        .idx_valid (idx_valid),
        .route     (route)
    );

    cfg_regfile #(
        .NUM_IMPL  (NUM_IMPL),
        .MAPEN_REG (MAPEN_REG),
        .MAPEN_BIT (MAPEN_BIT),
        .ID_LO     (ID_LO),
        .ID_HI     (ID_HI)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .claim  (route.claim),
        .is_wr  (route.is_wr),
        .slot   (route.slot),
        .wdata  (io_wdata),
        .rdata  (int_rdata),
        .map_en (map_en)
    );

    assign ext_req   = route.fwd;
    assign ext_wr    = io_wr;
    assign ext_addr  = io_addr;
    assign ext_wdata = io_wdata;
    assign io_rdata  = route.claim ? int_rdata : ext_rdata;

    // R2: a claimed data access never starts an external cycle
    a_r2_claimed_silent: assert property (@(posedge clk) disable iff (rst)
        ((io_rd || io_wr) && io_addr == PORT_DATA && idx_valid && in_claimed(idx_q)) |-> !ext_req);

    // R1: index writes always reach the external bus
    a_r1_index_forwarded: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == PORT_INDEX) |-> (ext_req && ext_wr && ext_wdata == io_wdata));

    // R11: no core strobe, no external cycle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!io_rd && !io_wr) |-> !ext_req);

endmodule

// File: tb/cfgport_decoder_tb.sv
`timescale 1ns/1ps
module cfgport_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        ext_req;
    logic        ext_wr;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic [7:0]  ext_rdata = '0;
    logic        map_en;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [4];
    logic [7:0] s_rdata;
    logic       s_req, s_wr;
    logic [15:0] s_addr;
    logic [7:0] s_wdata;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfgport_decoder u_dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ext_req(ext_req), .ext_wr(ext_wr),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .map_en(map_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one-cycle core access; outputs sampled mid-cycle before the commit edge
    task automatic cyc(input bit wr, input logic [15:0] a, input logic [7:0] d, input logic [7:0] xd);
        @(negedge clk);
        io_addr = a; io_wr = wr; io_rd = !wr; io_wdata = d; ext_rdata = xd;
        #1;
        s_rdata = io_rdata; s_req = ext_req; s_wr = ext_wr; s_addr = ext_addr; s_wdata = ext_wdata;
        @(posedge clk);
        #1;
        io_wr = 0; io_rd = 0;
    endtask

    function automatic bit claimed(input logic [7:0] i);
        return (i >= 8'hC0 && i <= 8'hCF) || i == 8'hFE || i == 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] i, input logic [7:0] xd);
        if (i >= 8'hC0 && i <= 8'hC3) return mdl[i - 8'hC0];
        if (i >= 8'hC4 && i <= 8'hCF) return 8'h00;
        if (i == 8'hFE) return 8'h5A;
        if (i == 8'hFF) return 8'h3C;
        return xd;
    endfunction

    initial begin
        #200000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk); #1;
        // R10 / R9 / R11: reset state
        chk(map_en == 0, "R9 map_en after reset", map_en, 0);
        chk(ext_req == 0, "R11 idle ext_req", ext_req, 0);
        // R10: data read with no index is forwarded, not claimed
        cyc(0, 16'h0023, 8'h00, 8'h77);
        chk(s_req == 1 && s_rdata == 8'h77, "R10 no valid index after reset", s_rdata, 8'h77);
        for (int k = 0; k < 4; k++) begin
            cyc(1, 16'h0022, 8'hC0 + 8'(k), 8'h00);
            cyc(0, 16'h0023, 8'h00, 8'hEE);
            chk(s_rdata == 8'h00 && s_req == 0, "R10 reg reset value", s_rdata, 0);
        end

        // exhaustive index sweep: write then read each index
        for (int i = 0; i < 256; i++) begin
            logic [7:0] idx = 8'(i);
            logic [7:0] pat = idx ^ 8'hA5;
            logic [7:0] xd  = (i % 2 == 0) ? 8'h00 : 8'hFF;
            cyc(1, 16'h0022, idx, 8'h00);
            chk(s_req && s_wr && s_addr == 16'h0022 && s_wdata == idx, "R1 index write forwarded", s_wdata, idx);
            cyc(1, 16'h0023, pat, 8'h00);
            if (claimed(idx)) begin
                chk(s_req == 0, "R2 claimed write no ext cycle", s_req, 0);
                if (idx >= 8'hC0 && idx <= 8'hC3) mdl[idx - 8'hC0] = pat; // R6
            end else begin
                chk(s_req && s_wr && s_addr == 16'h0023 && s_wdata == pat, "R3 unclaimed write forwarded", s_wdata, pat);
            end
            cyc(1, 16'h0022, idx, 8'h00);
            cyc(0, 16'h0023, 8'h00, xd);
            if (claimed(idx))
                chk(s_req == 0 && s_rdata == exp_read(idx, xd), "R2/R6/R7/R8 claimed read", s_rdata, exp_read(idx, xd));
            else
                chk(s_req && !s_wr && s_rdata == xd, "R4 forwarded read pass-through", s_rdata, xd);
        end

        // R3: unclaimed writes left on-chip registers unchanged
        for (int k = 0; k < 4; k++) begin
            cyc(1, 16'h0022, 8'hC0 + 8'(k), 8'h00);
            cyc(0, 16'h0023, 8'h00, 8'h99);
            chk(s_rdata == mdl[k], "R3 registers untouched by forwarded writes", s_rdata, mdl[k]);
        end

        // R5: second data access without fresh index is forwarded
        cyc(1, 16'h0022, 8'hC1, 8'h00);
        cyc(0, 16'h0023, 8'h00, 8'h11);
        chk(s_req == 0 && s_rdata == mdl[1], "R5 first access claimed", s_rdata, mdl[1]);
        cyc(0, 16'h0023, 8'h00, 8'h22);
        chk(s_req == 1 && s_rdata == 8'h22, "R5 stale index forwarded", s_rdata, 8'h22);
        cyc(1, 16'h0023, 8'h44, 8'h00);
        chk(s_req == 1, "R5 stale write forwarded", s_req, 1);
        cyc(1, 16'h0022, 8'hC1, 8'h00);
        cyc(0, 16'h0023, 8'h00, 8'h00);
        chk(s_rdata == mdl[1], "R5 stale write did not land", s_rdata, mdl[1]);

        // R9: map enable follows bit 4 of C3h
        cyc(1, 16'h0022, 8'hC3, 8'h00);
        cyc(1, 16'h0023, 8'h10, 8'h00);
        #1 chk(map_en == 1, "R9 map_en set", map_en, 1);
        cyc(1, 16'h0022, 8'hC3, 8'h00);
        cyc(1, 16'h0023, 8'hEF, 8'h00);
        #1 chk(map_en == 0, "R9 map_en cleared", map_en, 0);

        // R8: ID write ignored
        cyc(1, 16'h0022, 8'hFE, 8'h00);
        cyc(1, 16'h0023, 8'h00, 8'h00);
        cyc(1, 16'h0022, 8'hFE, 8'h00);
        cyc(0, 16'h0023, 8'h00, 8'h00);
        chk(s_rdata == 8'h5A, "R8 ID_LO after write", s_rdata, 8'h5A);

        // R11: other ports and index-port reads forwarded
        cyc(0, 16'h0022, 8'h00, 8'hC5);
        chk(s_req && !s_wr && s_rdata == 8'hC5, "R11 index port read forwarded", s_rdata, 8'hC5);
        cyc(1, 16'h0080, 8'h3A, 8'h00);
        chk(s_req && s_addr == 16'h0080 && s_wdata == 8'h3A, "R11 other port write", s_addr, 16'h0080);
        cyc(0, 16'h03F8, 8'h00, 8'hFF);
        chk(s_req && s_rdata == 8'hFF, "R11 other port read", s_rdata, 8'hFF);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule